// File: doc/BRIEF.md
# Transactional Enclave Event Disposition Unit

This unit decides what happens when an event occurs inside a hardware memory transaction that runs within a protected enclave. The event can be a data access refused by enclave page ownership, a debug trap or a breakpoint. The unit either aborts the transaction quietly and sends execution to the fallback handler, possibly with a general-protection fault, or it promotes the event to a debug exception aimed back at the address where the transaction began. A promoted event also forces an asynchronous enclave exit and updates either the debug-status bit or the pending-debug bit.

A small state machine records how the enclave was entered. The entry mode and the two debug-enable bits are captured when the entry strobe fires and stay fixed until exit or reset. Each event is classified against that captured state in the same cycle. Every result is registered, so the strobes appear exactly one clock after the event.

The state machine has four states:
- `S_OUT`: no enclave is active.
- `S_OPTOUT`: the enclave was entered in opt-out mode.
- `S_OPTIN_MUTED`: the enclave was entered in opt-in mode with at least one enable at 0.
- `S_OPTIN_ARMED`: the enclave was entered in opt-in mode with both enables at 1.

It has three transitions:
- ENTER: from `S_OUT` on `enter_valid_i`.
- LEAVE: any enclave state returns to `S_OUT` on `exit_valid_i`.
- AEX_EXIT: `S_OPTIN_ARMED` returns to `S_OUT` when an event is promoted.

Top module: `txn_evt_disp`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every output strobe is 0, `exc_vec_o` is 0 and `rip_o` is 0.
- R2: An event is active when `evt_valid_i` is 1, `txn_active_i` is 1 and an enclave is active. An active event of kind 0 (access refused) asserts `abort_o` and `redir_o` one cycle later, with `rip_o` equal to `fb_addr_i`. If `fb_inside_i` is 1, `exc_valid_o` stays 0.
- R3: A quiet abort with `fb_inside_i` at 0 also asserts `exc_valid_o` with `exc_vec_o` = 2 (general protection). `rip_o` still holds the fallback address, and `aex_o` stays 0.
- R4: In an opt-out enclave, kinds 1 (debug) and 2 (breakpoint) produce only a quiet abort to the fallback address, whatever the two enable bits are.
- R5: In an opt-in enclave with `dr_en_i` or `msr_en_i` at 0 when it was entered, kinds 1 and 2 produce only a quiet abort.
- R6: In an opt-in enclave with both enables at 1 when it was entered, kinds 1 and 2 produce the following one cycle later:
  - `abort_o`, `redir_o` and `aex_o` at 1;
  - `exc_valid_o` at 1 with `exc_vec_o` = 1 (debug), even for a breakpoint;
  - `rip_o` equal to `txn_begin_i`.
  No general-protection fault is raised, whatever `fb_inside_i` is.
- R7: A promoted event with `vmexit_i` at 0 pulses `dbgstat_clr_o` and leaves `pend_set_o` at 0.
- R8: A promoted event with `vmexit_i` at 1 pulses `pend_set_o` and leaves `dbgstat_clr_o` at 0.
- R9: The entry mode and both enable bits are captured on `enter_valid_i` while no enclave is active. Later changes to those inputs have no effect until the next entry. A promoted event ends the enclave (AEX_EXIT), and `exit_valid_i` ends it too (LEAVE).
- R10: An event with `txn_active_i` at 0, an event while no enclave is active, and an event of kind 3 all produce no strobe.
- R11: Each output strobe is high for exactly the one cycle that follows the accepted event, and only then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enter_valid_i | input | 1 | Enclave entry strobe |
| enter_optin_i | input | 1 | Entry mode: 1 = opt-in debug, 0 = opt-out |
| dr_en_i | input | 1 | Transaction-debug enable from the debug control register |
| msr_en_i | input | 1 | Transaction-debug enable from the debug-control MSR |
| exit_valid_i | input | 1 | Enclave exit strobe |
| txn_active_i | input | 1 | A memory transaction is in progress |
| evt_valid_i | input | 1 | Event strobe |
| evt_kind_i | input | 2 | Event kind: 0 refused access, 1 debug, 2 breakpoint, 3 reserved |
| fb_inside_i | input | 1 | The fallback handler lies inside the enclave |
| vmexit_i | input | 1 | The event causes a VM exit |
| txn_begin_i | input | AW | Saved transaction-begin address |
| fb_addr_i | input | AW | Fallback handler address |
| abort_o | output | 1 | Transaction abort strobe |
| exc_valid_o | output | 1 | Exception delivery strobe |
| exc_vec_o | output | 2 | Exception code: 1 debug, 2 general protection |
| aex_o | output | 1 | Asynchronous enclave exit |
| redir_o | output | 1 | `rip_o` carries a new instruction pointer |
| rip_o | output | AW | Redirected instruction pointer |
| dbgstat_clr_o | output | 1 | Clear strobe for the transaction bit of the debug status |
| pend_set_o | output | 1 | Set strobe for the transaction bit of the pending-debug field |

## Verification
The bench builds the unit with AW = 20. It uses fallback and begin addresses that differ in both their upper and lower bits, so that a wrong source on the instruction-pointer multiplexer shows up in every check. With this one width, the bench enters the enclave in all three modes and toggles the enable inputs after entry. It also crosses each event kind with the fallback-location and VM-exit flags, which covers each state and each transition of the state machine.

// File: rtl/txn_evt_pkg.sv
package txn_evt_pkg;

    typedef enum logic [1:0] {
        EV_DENIED = 2'd0,
        EV_DBG    = 2'd1,
        EV_BRK    = 2'd2,
        EV_RSVD   = 2'd3
    } evt_kind_e;

    typedef enum logic [1:0] {
        VEC_NONE = 2'd0,
        VEC_DB   = 2'd1,
        VEC_GP   = 2'd2
    } vec_e;

    typedef enum logic [1:0] {
        S_OUT,
        S_OPTOUT,
        S_OPTIN_MUTED,
        S_OPTIN_ARMED
    } encl_state_e;

    typedef struct packed {
        logic abort;
        logic exc;
        vec_e vec;
        logic aex;
        logic redir;
        logic use_begin;
        logic clr;
        logic pend;
    } disp_t;

endpackage

// File: rtl/txn_evt_mode_fsm.sv
module txn_evt_mode_fsm
    import txn_evt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        enter_valid_i,
    input  logic        enter_optin_i,
    input  logic        dr_en_i,
    input  logic        msr_en_i,
    input  logic        exit_valid_i,
    input  logic        aex_fire_i,
    output encl_state_e state_o
);

    encl_state_e state_q;
    encl_state_e state_d;

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_OUT: begin
                // ENTER
                if (enter_valid_i) begin
                    if (!enter_optin_i)
                        state_d = S_OPTOUT;
                    else if (dr_en_i && msr_en_i)
                        state_d = S_OPTIN_ARMED;
                    else
                        state_d = S_OPTIN_MUTED;
                end
            end
            S_OPTOUT, S_OPTIN_MUTED: begin
                // LEAVE
                if (exit_valid_i)
                    state_d = S_OUT;
            end
            S_OPTIN_ARMED: begin
                // LEAVE or AEX_EXIT
                if (exit_valid_i || aex_fire_i)
                    state_d = S_OUT;
            end
            default: state_d = S_OUT;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= S_OUT;
        else
            state_q <= state_d;
    end

    assign state_o = state_q;

endmodule

// File: rtl/txn_evt_decide.sv
module txn_evt_decide
    import txn_evt_pkg::*;
(
    input  encl_state_e state_i,
    input  logic        evt_valid_i,
    input  logic [1:0]  evt_kind_i,
    input  logic        txn_active_i,
    input  logic        fb_inside_i,
    input  logic        vmexit_i,
    output disp_t       disp_o
);

    logic      live;
    logic      quiet;
    logic      promote;
    evt_kind_e kind;

    assign kind = evt_kind_e'(evt_kind_i);
    assign live = evt_valid_i && txn_active_i && (state_i != S_OUT);

    // classify the event against the captured entry state
    always_comb begin
        quiet   = 1'b0;
        promote = 1'b0;
        if (live) begin
            unique case (kind)
                EV_DENIED: quiet = 1'b1;
                EV_DBG, EV_BRK: begin
                    if (state_i == S_OPTIN_ARMED)
                        promote = 1'b1;
                    else
                        quiet = 1'b1;
                end
                default: ;
            endcase
        end
    end

    // build the disposition word
    always_comb begin
        disp_o     = '0;
        disp_o.vec = VEC_NONE;
        if (quiet) begin
            disp_o.abort     = 1'b1;
            disp_o.redir     = 1'b1;
            disp_o.use_begin = 1'b0;
            if (!fb_inside_i) begin
                disp_o.exc = 1'b1;
                disp_o.vec = VEC_GP;
            end
        end else if (promote) begin
            disp_o.abort     = 1'b1;
            disp_o.redir     = 1'b1;
            disp_o.use_begin = 1'b1;
            disp_o.exc       = 1'b1;
            disp_o.vec       = VEC_DB;
            disp_o.aex       = 1'b1;
            disp_o.clr       = !vmexit_i;
            disp_o.pend      = vmexit_i;
        end
    end

endmodule

// File: rtl/txn_evt_disp.sv
module txn_evt_disp
    import txn_evt_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enter_valid_i,
    input  logic          enter_optin_i,
    input  logic          dr_en_i,
    input  logic          msr_en_i,
    input  logic          exit_valid_i,
    input  logic          txn_active_i,
    input  logic          evt_valid_i,
    input  logic [1:0]    evt_kind_i,
    input  logic          fb_inside_i,
    input  logic          vmexit_i,
    input  logic [AW-1:0] txn_begin_i,
    input  logic [AW-1:0] fb_addr_i,
    output logic          abort_o,
    output logic          exc_valid_o,
    output logic [1:0]    exc_vec_o,
    output logic          aex_o,
    output logic          redir_o,
    output logic [AW-1:0] rip_o,
    output logic          dbgstat_clr_o,
    output logic          pend_set_o
);

    encl_state_e   state_q;
    disp_t         disp_d;
    disp_t         disp_q;
    logic [AW-1:0] rip_d;
    logic [AW-1:0] rip_q;

    txn_evt_mode_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .enter_valid_i (enter_valid_i),
        .enter_optin_i (enter_optin_i),
        .dr_en_i       (dr_en_i),
        .msr_en_i      (msr_en_i),
        .exit_valid_i  (exit_valid_i),
        .aex_fire_i    (disp_d.aex),
        .state_o       (state_q)
    );

    txn_evt_decide u_dec (
        .state_i      (state_q),
        .evt_valid_i  (evt_valid_i),
        .evt_kind_i   (evt_kind_i),
        .txn_active_i (txn_active_i),
        .fb_inside_i  (fb_inside_i),
        .vmexit_i     (vmexit_i),
        .disp_o       (disp_d)
    );

    always_comb begin
        rip_d = '0;
        if (disp_d.redir)
            rip_d = disp_d.use_begin ? txn_begin_i : fb_addr_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            disp_q <= '0;
            rip_q  <= '0;
        end else begin
            disp_q <= disp_d;
            rip_q  <= rip_d;
        end
    end

    // output process
    always_comb begin
        abort_o       = disp_q.abort;
        exc_valid_o   = disp_q.exc;
        exc_vec_o     = disp_q.vec;
        aex_o         = disp_q.aex;
        redir_o       = disp_q.redir;
        rip_o         = rip_q;
        dbgstat_clr_o = disp_q.clr;
        pend_set_o    = disp_q.pend;
    end

endmodule

// File: rtl/txn_evt_disp_chk.sv
module txn_evt_disp_chk
    import txn_evt_pkg::*;
#(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          evt_valid_i,
    input logic          txn_active_i,
    input logic          vmexit_i,
    input logic [AW-1:0] txn_begin_i,
    input logic [AW-1:0] fb_addr_i,
    input logic          abort_o,
    input logic          exc_valid_o,
    input logic [1:0]    exc_vec_o,
    input logic          aex_o,
    input logic          redir_o,
    input logic [AW-1:0] rip_o,
    input logic          dbgstat_clr_o,
    input logic          pend_set_o,
    input encl_state_e   state_q
);

    p_quiet_rip_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_o && !aex_o) |-> (redir_o && rip_o == $past(fb_addr_i)));

    p_gp_shape_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid_o && exc_vec_o == VEC_GP) |-> (abort_o && !aex_o && !dbgstat_clr_o && !pend_set_o));

    p_promote_r6: assert property (@(posedge clk) disable iff (!rst_n)
        aex_o |-> (exc_valid_o && exc_vec_o == VEC_DB && abort_o && rip_o == $past(txn_begin_i)));

    p_clr_novm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dbgstat_clr_o |-> (aex_o && !$past(vmexit_i)));

    p_pend_vm_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pend_set_o |-> (aex_o && $past(vmexit_i)));

    p_aex_leaves_r9: assert property (@(posedge clk) disable iff (!rst_n)
        aex_o |-> (state_q == S_OUT));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt_valid_i || !txn_active_i) |=> !(abort_o || exc_valid_o || redir_o || aex_o));

    p_strobe_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_o || exc_valid_o || dbgstat_clr_o || pend_set_o) |-> $past(evt_valid_i));

endmodule

bind txn_evt_disp txn_evt_disp_chk #(.AW(AW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .evt_valid_i   (evt_valid_i),
    .txn_active_i  (txn_active_i),
    .vmexit_i      (vmexit_i),
    .txn_begin_i   (txn_begin_i),
    .fb_addr_i     (fb_addr_i),
    .abort_o       (abort_o),
    .exc_valid_o   (exc_valid_o),
    .exc_vec_o     (exc_vec_o),
    .aex_o         (aex_o),
    .redir_o       (redir_o),
    .rip_o         (rip_o),
    .dbgstat_clr_o (dbgstat_clr_o),
    .pend_set_o    (pend_set_o),
    .state_q       (state_q)
);

// File: tb/sim_txn_evt_disp.sv
module sim_txn_evt_disp;

    localparam int AW = 20;
    localparam logic [AW-1:0] BEGIN_A = 20'hA5C3E;
    localparam logic [AW-1:0] FB_A    = 20'h3B71D;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enter_valid_i = 1'b0;
    logic          enter_optin_i = 1'b0;
    logic          dr_en_i = 1'b0;
    logic          msr_en_i = 1'b0;
    logic          exit_valid_i = 1'b0;
    logic          txn_active_i = 1'b1;
    logic          evt_valid_i = 1'b0;
    logic [1:0]    evt_kind_i = 2'd0;
    logic          fb_inside_i = 1'b1;
    logic          vmexit_i = 1'b0;
    logic [AW-1:0] txn_begin_i = BEGIN_A;
    logic [AW-1:0] fb_addr_i = FB_A;
    logic          abort_o;
    logic          exc_valid_o;
    logic [1:0]    exc_vec_o;
    logic          aex_o;
    logic          redir_o;
    logic [AW-1:0] rip_o;
    logic          dbgstat_clr_o;
    logic          pend_set_o;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    txn_evt_disp #(.AW(AW)) u0 (.*);

    // {abort, exc, vec[1:0], aex, redir, clr, pend}
    function automatic logic [7:0] pk(input logic a, input logic e, input logic [1:0] v,
                                      input logic x, input logic r, input logic c, input logic p);
        return {a, e, v, x, r, c, p};
    endfunction

    function automatic logic [7:0] obs();
        return {abort_o, exc_valid_o, exc_vec_o, aex_o, redir_o, dbgstat_clr_o, pend_set_o};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic enter(input logic optin, input logic dr, input logic msr);
        @(negedge clk);
        enter_valid_i = 1'b1; enter_optin_i = optin; dr_en_i = dr; msr_en_i = msr;
        @(negedge clk);
        enter_valid_i = 1'b0;
    endtask

    task automatic leave();
        @(negedge clk);
        exit_valid_i = 1'b1;
        @(negedge clk);
        exit_valid_i = 1'b0;
    endtask

    // fire one event, sample the cycle after, then confirm strobes fall
    task automatic fire(input string req, input logic [1:0] kind, input logic fbin, input logic vm,
                        input logic [7:0] exp_w, input logic [AW-1:0] exp_rip);
        @(negedge clk);
        evt_valid_i = 1'b1; evt_kind_i = kind; fb_inside_i = fbin; vmexit_i = vm;
        @(posedge clk); #1;
        chk(req, {24'd0, obs()}, {24'd0, exp_w});
        chk(req, {12'd0, rip_o}, {12'd0, exp_rip});
        @(negedge clk);
        evt_valid_i = 1'b0;
        @(posedge clk); #1;
        chk("R11", {24'd0, obs()}, 32'd0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 chk("R1", {24'd0, obs()}, 32'd0);
        chk("R1", {12'd0, rip_o}, 32'd0);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1", {24'd0, obs()}, 32'd0);
    endtask

    task automatic t_denied();
        enter(1'b1, 1'b1, 1'b1);
        fire("R2", 2'd0, 1'b1, 1'b0, pk(1,0,2'd0,0,1,0,0), FB_A);
        fire("R3", 2'd0, 1'b0, 1'b0, pk(1,1,2'd2,0,1,0,0), FB_A);
        leave();
    endtask

    task automatic t_optout();
        enter(1'b0, 1'b1, 1'b1);
        fire("R4", 2'd1, 1'b1, 1'b0, pk(1,0,2'd0,0,1,0,0), FB_A);
        fire("R4", 2'd2, 1'b0, 1'b1, pk(1,1,2'd2,0,1,0,0), FB_A);
        leave();
    endtask

    task automatic t_optin_muted();
        enter(1'b1, 1'b0, 1'b1);
        fire("R5", 2'd1, 1'b1, 1'b0, pk(1,0,2'd0,0,1,0,0), FB_A);
        leave();
        enter(1'b1, 1'b1, 1'b0);
        fire("R5", 2'd2, 1'b0, 1'b0, pk(1,1,2'd2,0,1,0,0), FB_A);
        // enables rise after entry: still muted
        @(negedge clk); dr_en_i = 1'b1; msr_en_i = 1'b1;
        fire("R9", 2'd1, 1'b1, 1'b0, pk(1,0,2'd0,0,1,0,0), FB_A);
        leave();
    endtask

    task automatic t_promote_novm();
        enter(1'b1, 1'b1, 1'b1);
        @(negedge clk); dr_en_i = 1'b0;  // change after entry has no effect
        fire("R6 R7", 2'd2, 1'b0, 1'b0, pk(1,1,2'd1,1,1,1,0), BEGIN_A);
        // AEX left the enclave: next event has no effect
        fire("R9", 2'd1, 1'b1, 1'b0, 8'd0, '0);
    endtask

    task automatic t_promote_vm();
        enter(1'b1, 1'b1, 1'b1);
        fire("R6 R8", 2'd1, 1'b1, 1'b1, pk(1,1,2'd1,1,1,0,1), BEGIN_A);
    endtask

    task automatic t_passthrough();
        enter(1'b1, 1'b1, 1'b1);
        @(negedge clk); txn_active_i = 1'b0;
        fire("R10", 2'd1, 1'b0, 1'b0, 8'd0, '0);
        @(negedge clk); txn_active_i = 1'b1;
        fire("R10", 2'd3, 1'b0, 1'b0, 8'd0, '0);
        leave();
        fire("R10", 2'd0, 1'b0, 1'b0, 8'd0, '0);
    endtask

    initial begin
        t_reset();
        t_denied();
        t_optout();
        t_optin_muted();
        t_promote_novm();
        t_promote_vm();
        t_passthrough();
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule